// File: doc/BRIEF.md
# Crystal and PLL Power Sequencer

This block drives the power controls of an on-board crystal oscillator and of the PLL that runs from it. Each control is one output bit with its own output-enable bit. A single-cycle request carries a direction (power up or power down) and a two-bit resource mask. The block then walks through the writes and settle delays that direction needs, and reports completion with a one-cycle pulse.

Power-up is ordered. The crystal is started first, with the PLL held in power-down. After a crystal settle time the PLL is released, and a PLL settle time follows. The PLL control is active-low, so a 1 holds it powered down. The PLL state cannot be read back. If the crystal sense input already shows the oscillator running, the PLL is assumed to be running too, and both power steps are skipped so the running clock is not disturbed. Every power-up request ends with a one-cycle pulse that clears a sticky signalled-target-abort status flag elsewhere. Power-down applies its writes at once, with no delay.

The settle times are given in microseconds. They are converted to cycle counts from a clock-frequency parameter given in kHz.

Top module: `pwrseq_top`

## Requirements
- R1: After reset the crystal bit is 0, the PLL bit is 1 (PLL held off), both enable bits are 0, and the clear pulse and done are low.
- R2: An accepted request sets the enable bit of every selected resource (mask bit 0 = crystal, bit 1 = PLL) in the cycle after the start strobe, on both power-up and power-down. Enable bits are never cleared except by reset.
- R3: On power-up with the crystal selected and the sense input low, the crystal bit goes to 1 in the cycle after the start strobe. If the PLL is also selected, the PLL bit goes to 1 in that same cycle.
- R4: The PLL bit is released to 0 exactly XTAL_CYC cycles after the crystal bit was set when both resources are selected. When only the PLL is selected, it is released in the cycle after the start strobe.
- R5: The clear pulse follows the PLL release by exactly PLL_CYC cycles. For a crystal-only power-up it follows the crystal set by XTAL_CYC cycles.
- R6: Every power-up request produces exactly one single-cycle clear pulse. A power-down request never produces one.
- R7: On power-up with the sense input high, neither control bit changes. The clear pulse comes in the cycle after the start strobe.
- R8: On power-down the crystal bit goes to 0 if selected and the PLL bit to 1 if selected, both in the cycle after the start strobe. Done is high in that same cycle.
- R9: On power-up, done is a single-cycle pulse in the cycle right after the clear pulse.
- R10: A start strobe is ignored from the cycle it is accepted until the cycle after done, including the done cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| power_on_i | input | 1 | 1 = power up, 0 = power down |
| sel_i | input | 2 | Resource mask: bit 0 crystal, bit 1 PLL |
| xtal_sense_i | input | 1 | Crystal running indication |
| xtal_out_o | output | 1 | Crystal power control (1 = on) |
| pll_out_o | output | 1 | PLL power control (1 = off, 0 = run) |
| xtal_oe_o | output | 1 | Output enable of the crystal control |
| pll_oe_o | output | 1 | Output enable of the PLL control |
| abort_clr_o | output | 1 | One-cycle clear of the sticky target-abort flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two cases are hard to reach from the ports. One is a request that arrives while a sequence is running, especially in the done cycle, where the sequencer is already finishing. The other is a power-up skipped because the crystal is sensed as running while a power-down has left the PLL bit set. The stimulus fires a conflicting power-down strobe in the middle of a long wait, and another one in the very cycle done is seen. It also runs a power-up with the sense input forced high after a PLL-only power-down. A behavioural timeline model predicts every output on every cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int SEL_W    = 2;
    localparam int SEL_XTAL = 0;
    localparam int SEL_PLL  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XWAIT,
        ST_PWAIT,
        ST_CLEAR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic up;
        logic xtal;
        logic pll;
    } seq_req_t;

    typedef struct packed {
        logic             xtal_we;
        logic             xtal_val;
        logic             pll_we;
        logic             pll_val;
        logic [SEL_W-1:0] oe_set;
    } out_cmd_t;

    // settle time in microseconds -> clock cycles, at least one cycle
    function automatic int wait_cycles(input int clk_khz, input int wait_us);
        longint c;
        c = (longint'(clk_khz) * longint'(wait_us)) / 1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_outreg.sv
module pwrseq_outreg
    import pwrseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  out_cmd_t cmd,
    output logic     xtal_out_o,
    output logic     pll_out_o,
    output logic     xtal_oe_o,
    output logic     pll_oe_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            xtal_out_o <= 1'b0;
            pll_out_o  <= 1'b1;
            xtal_oe_o  <= 1'b0;
            pll_oe_o   <= 1'b0;
        end else begin
            if (cmd.xtal_we)          xtal_out_o <= cmd.xtal_val;
            if (cmd.pll_we)           pll_out_o  <= cmd.pll_val;
            if (cmd.oe_set[SEL_XTAL]) xtal_oe_o  <= 1'b1;
            if (cmd.oe_set[SEL_PLL])  pll_oe_o   <= 1'b1;
        end
    end

    AST_XTAL_OE_STICKY: assert property (@(posedge clk) disable iff (rst)
        xtal_oe_o |=> xtal_oe_o); // R2
    AST_PLL_OE_STICKY: assert property (@(posedge clk) disable iff (rst)
        pll_oe_o |=> pll_oe_o); // R2

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int          CW    = 8,
    parameter logic [CW-1:0] XLOAD = '0,
    parameter logic [CW-1:0] PLOAD = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             power_on_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             xtal_sense_i,
    input  logic             expired,
    output out_cmd_t         cmd,
    output logic             tmr_load,
    output logic [CW-1:0]    tmr_val,
    output logic             abort_clr_o,
    output logic             done_o
);
    seq_state_e st_q, st_d;
    seq_req_t   req_q, req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            req_q <= '0;
        end else begin
            st_q  <= st_d;
            req_q <= req_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        req_d    = req_q;
        cmd      = '0;
        tmr_load = 1'b0;
        tmr_val  = XLOAD;
        unique case (st_q)
            ST_IDLE: if (start_i) begin
                req_d.up   = power_on_i;
                req_d.xtal = sel_i[SEL_XTAL];
                req_d.pll  = sel_i[SEL_PLL];
                cmd.oe_set = sel_i;
                if (!power_on_i) begin
                    // power-down: immediate writes, no settle
                    cmd.xtal_we  = sel_i[SEL_XTAL];
                    cmd.xtal_val = 1'b0;
                    cmd.pll_we   = sel_i[SEL_PLL];
                    cmd.pll_val  = 1'b1;
                    st_d         = ST_DONE;
                end else if (xtal_sense_i) begin
                    // clock already running: leave both controls alone
                    st_d = ST_CLEAR;
                end else if (sel_i[SEL_XTAL]) begin
                    cmd.xtal_we  = 1'b1;
                    cmd.xtal_val = 1'b1;
                    cmd.pll_we   = sel_i[SEL_PLL];
                    cmd.pll_val  = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = XLOAD;
                    st_d         = ST_XWAIT;
                end else if (sel_i[SEL_PLL]) begin
                    cmd.pll_we  = 1'b1;
                    cmd.pll_val = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = PLOAD;
                    st_d        = ST_PWAIT;
                end else begin
                    st_d = ST_CLEAR;
                end
            end
            ST_XWAIT: if (expired) begin
                if (req_q.pll) begin
                    cmd.pll_we  = 1'b1;
                    cmd.pll_val = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = PLOAD;
                    st_d        = ST_PWAIT;
                end else begin
                    st_d = ST_CLEAR;
                end
            end
            ST_PWAIT: if (expired) st_d = ST_CLEAR;
            ST_CLEAR: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    assign abort_clr_o = (st_q == ST_CLEAR);
    assign done_o      = (st_q == ST_DONE);

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        abort_clr_o |=> !abort_clr_o); // R6
    AST_DONE_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
        abort_clr_o |=> done_o); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9
    AST_NO_CLR_ON_DOWN: assert property (@(posedge clk) disable iff (rst)
        (done_o && !req_q.up) |-> !abort_clr_o); // R6

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int CLK_KHZ      = 100000,
    parameter int XTAL_WAIT_US = 1000,
    parameter int PLL_WAIT_US  = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       power_on_i,
    input  logic [1:0] sel_i,
    input  logic       xtal_sense_i,
    output logic       xtal_out_o,
    output logic       pll_out_o,
    output logic       xtal_oe_o,
    output logic       pll_oe_o,
    output logic       abort_clr_o,
    output logic       done_o
);
    localparam int XTAL_CYC = wait_cycles(CLK_KHZ, XTAL_WAIT_US);
    localparam int PLL_CYC  = wait_cycles(CLK_KHZ, PLL_WAIT_US);
    localparam int MAX_CYC  = (XTAL_CYC > PLL_CYC) ? XTAL_CYC : PLL_CYC;
    localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CW-1:0] XLOAD = CW'(XTAL_CYC - 1);
    localparam logic [CW-1:0] PLOAD = CW'(PLL_CYC - 1);

    out_cmd_t      cmd;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          expired;

    pwrseq_fsm #(.CW(CW), .XLOAD(XLOAD), .PLOAD(PLOAD)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .power_on_i   (power_on_i),
        .sel_i        (sel_i),
        .xtal_sense_i (xtal_sense_i),
        .expired      (expired),
        .cmd          (cmd),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .abort_clr_o  (abort_clr_o),
        .done_o       (done_o)
    );

    pwrseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    pwrseq_outreg u_out (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .xtal_out_o (xtal_out_o),
        .pll_out_o  (pll_out_o),
        .xtal_oe_o  (xtal_oe_o),
        .pll_oe_o   (pll_oe_o)
    );

endmodule

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;
    localparam int XC = 10;   // 10 kHz * 1000 us / 1000
    localparam int PC = 50;   // 10 kHz * 5000 us / 1000

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, power_on_i = 1'b0, xtal_sense_i = 1'b0;
    logic [1:0] sel_i = 2'b00;
    logic xtal_out_o, pll_out_o, xtal_oe_o, pll_oe_o, abort_clr_o, done_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pwrseq_top #(.CLK_KHZ(10), .XTAL_WAIT_US(1000), .PLL_WAIT_US(5000)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .power_on_i(power_on_i),
        .sel_i(sel_i), .xtal_sense_i(xtal_sense_i),
        .xtal_out_o(xtal_out_o), .pll_out_o(pll_out_o),
        .xtal_oe_o(xtal_oe_o), .pll_oe_o(pll_oe_o),
        .abort_clr_o(abort_clr_o), .done_o(done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural timeline model ----------------
    bit m_busy = 0;
    int m_t = 0, pll_at = -1, clr_at = -1, done_at = -1;
    bit e_xo = 0, e_po = 1, e_xoe = 0, e_poe = 0, e_clr = 0, e_done = 0;

    task automatic m_events();
        if (m_t == pll_at)  e_po = 0;
        if (m_t == clr_at)  e_clr = 1;
        if (m_t == done_at) e_done = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; e_xo = 0; e_po = 1; e_xoe = 0; e_poe = 0;
            e_clr = 0; e_done = 0;
        end else begin
            e_clr = 0; e_done = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == done_at + 1) m_busy = 0;
                else m_events();
            end else if (start_i) begin
                m_busy = 1; m_t = 0; pll_at = -1;
                if (sel_i[0]) e_xoe = 1;
                if (sel_i[1]) e_poe = 1;
                if (!power_on_i) begin
                    if (sel_i[0]) e_xo = 0;
                    if (sel_i[1]) e_po = 1;
                    clr_at = -1; done_at = 0;
                end else if (xtal_sense_i || sel_i == 2'b00) begin
                    clr_at = 0; done_at = 1;
                end else if (sel_i[0]) begin
                    e_xo = 1;
                    if (sel_i[1]) begin e_po = 1; pll_at = XC; clr_at = XC + PC; end
                    else clr_at = XC;
                    done_at = clr_at + 1;
                end else begin
                    pll_at = 0; clr_at = PC; done_at = PC + 1;
                end
                m_events();
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R3", "xtal_out", int'(xtal_out_o), int'(e_xo));
            check("R4", "pll_out", int'(pll_out_o), int'(e_po));
            check("R2", "xtal_oe", int'(xtal_oe_o), int'(e_xoe));
            check("R2", "pll_oe", int'(pll_oe_o), int'(e_poe));
            check("R6", "abort_clr", int'(abort_clr_o), int'(e_clr));
            check("R9", "done", int'(done_o), int'(e_done));
        end
    end

    // returns index of the done cycle (0 = cycle right after the start edge)
    task automatic run(input bit on, input logic [1:0] sel, input bit sense, output int lat);
        @(negedge clk);
        power_on_i = on; sel_i = sel; xtal_sense_i = sense; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    int lat;
    int clr_seen;

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "xtal_out", int'(xtal_out_o), 0);
        check("R1", "pll_out", int'(pll_out_o), 1);
        check("R1", "oe", int'({xtal_oe_o, pll_oe_o}), 0);
        check("R1", "clr/done", int'({abort_clr_o, done_o}), 0);
        rst = 1'b0;

        // full power-up: R3 R4 R5 R9
        run(1, 2'b11, 0, lat);
        check("R5", "up both latency", lat, XC + PC + 1);
        check("R4", "pll released", int'(pll_out_o), 0);
        check("R3", "xtal on", int'(xtal_out_o), 1);

        // power-down both: R8
        run(0, 2'b11, 0, lat);
        check("R8", "down latency", lat, 0);
        check("R8", "xtal off", int'(xtal_out_o), 0);
        check("R8", "pll off", int'(pll_out_o), 1);
        check("R6", "no clr on down", int'(abort_clr_o), 0);

        // crystal only: R5 R2
        run(1, 2'b01, 0, lat);
        check("R5", "xtal-only latency", lat, XC + 1);
        check("R2", "pll oe kept", int'(pll_oe_o), 1);

        // PLL only: R4
        run(1, 2'b10, 0, lat);
        check("R4", "pll-only latency", lat, PC + 1);

        // PLL-only down, then skipped power-up: R7
        run(0, 2'b10, 0, lat);
        run(1, 2'b11, 1, lat);
        check("R7", "skip latency", lat, 1);
        check("R7", "xtal untouched", int'(xtal_out_o), 1);
        check("R7", "pll untouched", int'(pll_out_o), 1);

        // empty mask power-up still clears: R6
        run(1, 2'b00, 0, lat);
        check("R6", "empty mask latency", lat, 1);

        // crystal-only down: R8
        run(0, 2'b01, 0, lat);
        check("R8", "xtal off only", int'(xtal_out_o), 0);
        check("R8", "pll left", int'(pll_out_o), 1);

        // R10: conflicting strobe mid-sequence and in the done cycle
        @(negedge clk);
        power_on_i = 1; sel_i = 2'b11; xtal_sense_i = 0; start_i = 1;
        @(negedge clk); start_i = 0;
        repeat (20) @(negedge clk);
        power_on_i = 0; sel_i = 2'b11; start_i = 1;
        @(negedge clk); start_i = 0;
        clr_seen = 0;
        while (!done_o) begin
            if (abort_clr_o) clr_seen++;
            @(negedge clk);
        end
        power_on_i = 0; sel_i = 2'b11; start_i = 1;   // during done cycle
        @(negedge clk); start_i = 0;
        check("R10", "clr after ignored strobe", clr_seen, 1);
        check("R10", "xtal still on", int'(xtal_out_o), 1);
        check("R10", "pll still running", int'(pll_out_o), 0);
        repeat (3) @(negedge clk);
        check("R10", "no extra done", int'(done_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule